// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog timer for a slow tick domain, normally 32 kHz. Software picks a timeout length and turns the block on. It then has to restart the timer before the count runs out. If it does not, the block drives a system reset pulse, or it first raises an interrupt. A simple 32-bit register port gives access to a mode word, a length word, a restart strobe and a software-reset strobe. Each control write must carry its own key. Each strobe must carry its own exact code word. Any other value leaves the block unchanged, so a runaway program that writes to the registers cannot easily stop the timer by accident.

The timeout is counted in units of 512 ticks, so N seconds at 32 kHz is a length of N×64. A single flat down-counter holds the remaining ticks. It is reloaded by a restart, by an accepted length write, and by every expiry. The reset pulse lasts a fixed 32 ticks. It appears on an internal active-high output and on an external pin whose polarity and enable come from the mode word. In dual mode the first expiry only raises the interrupt, and a second expiry with no restart in between escalates to reset.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the mode word reads 0, the length word reads 1984 units (0x0000F800), `sys_rst_o` and `irq_o` are 0, and `ext_rst_o` sits at its inactive level 1.
- R2: A write to offset 0x00 is accepted only when bits 31:24 equal 0x22. Otherwise it is ignored. The stored bits are enable (0), pin polarity active-high (1), pin enable (2), interrupt enable (3), auto-start (4) and dual (6), and they read back at those positions. All other read bits are 0.
- R3: A write to offset 0x04 is accepted only when bits 4:0 equal 0x08. The length is taken from bits 15:5 and reads back there with bits 4:0 as zero. An accepted length write also reloads the counter.
- R4: With enable set and interrupt enable clear, `sys_rst_o` rises exactly length×512 cycles after the last reload edge and stays high for 32 cycles. The counter reloads at that expiry.
- R5: Writing exactly 0x00001971 to offset 0x08 reloads the counter. Any other value at that offset has no effect. Offsets 0x08 and 0x14 read as 0.
- R6: Writing exactly 0x00001209 to offset 0x14 makes `sys_rst_o` high from the next cycle for 32 cycles, whether or not the timer is enabled. Other values are ignored.
- R7: While enable is clear the counter holds its value and no expiry reset is generated.
- R8: `ext_rst_o` follows the reset pulse only when the pin enable bit is set. It is active high when the polarity bit is 1 and active low when it is 0. Otherwise it stays at the inactive level.
- R9: With interrupt enable set and dual clear, an expiry raises `irq_o` and no reset. `irq_o` stays high until a restart or until enable or interrupt enable is cleared.
- R10: With interrupt enable and dual set, the first expiry raises `irq_o` and reloads the counter. A second expiry with no restart in between starts the reset pulse and clears `irq_o`. A restart drops `irq_o` and returns to the first stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 5 | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data, including key or code |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| sys_rst_o | output | 1 | Internal active-high reset pulse |
| ext_rst_o | output | 1 | External reset pin, polarity and enable from mode |
| irq_o | output | 1 | Pre-reset interrupt, level |

## Verification
Register readback is due one cycle after the write edge. The software reset pulse is high from the cycle after its write edge through 31 more cycles. An expiry pulse or interrupt is due exactly length×512 cycles after the reload edge, and it is followed by the low edge 32 cycles later. A restart clears the interrupt in the cycle after its write edge. The driver records the cycle of each write edge and queues each expected value with an absolute due cycle computed from these latencies. The monitor samples every output a quarter period after each rising edge and compares only the entries due in that cycle. An entry that has slipped past its cycle counts as a failure.

// File: rtl/keyed_wdt_pkg.sv
`timescale 1ns/1ps
package keyed_wdt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  // byte offsets
  localparam logic [ADDR_W-1:0] OFS_MODE  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_LEN   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_KICK  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_SWRST = 5'h14;

  localparam logic [7:0]        MODE_KEY   = 8'h22;
  localparam int unsigned       LEN_LSB    = 5;
  localparam logic [LEN_LSB-1:0] LEN_KEY   = 5'h08;
  localparam logic [DATA_W-1:0] KICK_CODE  = 32'h0000_1971;
  localparam logic [DATA_W-1:0] SWRST_CODE = 32'h0000_1209;

  localparam int unsigned MODE_BITS = 7;
  localparam logic [MODE_BITS-1:0] MODE_MASK = 7'h5F;
  localparam int unsigned MB_EN   = 0;
  localparam int unsigned MB_POL  = 1;
  localparam int unsigned MB_EXT  = 2;
  localparam int unsigned MB_IRQ  = 3;
  localparam int unsigned MB_DUAL = 6;

  typedef struct packed {
    logic dual;
    logic irq_en;
    logic ext_en;
    logic pol_hi;
    logic en;
  } mode_t;
endpackage

// File: rtl/kwdt_regfile.sv
`timescale 1ns/1ps
module kwdt_regfile
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned LEN_RST = 1984
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output mode_t             mode_o,
  output logic [LEN_W-1:0]  len_next_o,
  output logic              reload_o,
  output logic              kick_o,
  output logic              swrst_o
);
  logic [MODE_BITS-1:0] mode_q;
  logic [LEN_W-1:0]     len_q;
  logic hit_mode, hit_len;

  assign hit_mode = we_i && (addr_i == OFS_MODE) && (wdata_i[DATA_W-1 -: 8] == MODE_KEY);
  assign hit_len  = we_i && (addr_i == OFS_LEN)  && (wdata_i[LEN_LSB-1:0] == LEN_KEY);
  assign kick_o   = we_i && (addr_i == OFS_KICK)  && (wdata_i == KICK_CODE);
  assign swrst_o  = we_i && (addr_i == OFS_SWRST) && (wdata_i == SWRST_CODE);

  assign reload_o   = hit_len || kick_o;
  // reload must see the length being written this cycle
  assign len_next_o = hit_len ? wdata_i[LEN_LSB +: LEN_W] : len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      len_q  <= LEN_W'(LEN_RST);
    end else begin
      if (hit_mode) mode_q <= wdata_i[MODE_BITS-1:0] & MODE_MASK;
      if (hit_len)  len_q  <= wdata_i[LEN_LSB +: LEN_W];
    end
  end

  assign mode_o.en     = mode_q[MB_EN];
  assign mode_o.pol_hi = mode_q[MB_POL];
  assign mode_o.ext_en = mode_q[MB_EXT];
  assign mode_o.irq_en = mode_q[MB_IRQ];
  assign mode_o.dual   = mode_q[MB_DUAL];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MODE: rdata_o[MODE_BITS-1:0] = mode_q;
      OFS_LEN:  rdata_o[LEN_LSB +: LEN_W] = len_q;
      default:  rdata_o = '0;
    endcase
  end

  assert_mode_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_MODE && wdata_i[DATA_W-1 -: 8] != MODE_KEY) |=> $stable(mode_q));
  assert_len_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_LEN && wdata_i[LEN_LSB-1:0] != LEN_KEY) |=> $stable(len_q));
endmodule

// File: rtl/kwdt_countdown.sv
`timescale 1ns/1ps
module kwdt_countdown #(
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned UNIT_TICKS = 512,
  parameter int unsigned LEN_RST    = 1984
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             expire_o
);
  localparam int unsigned CNT_W = LEN_W + $clog2(UNIT_TICKS);

  logic [CNT_W-1:0] cnt_q, load_val;

  assign load_val = CNT_W'(len_i) * CNT_W'(UNIT_TICKS);
  // last tick of the period; a reload in the same cycle wins
  assign expire_o = en_i && !reload_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= CNT_W'(LEN_RST) * CNT_W'(UNIT_TICKS);
    else if (reload_i || expire_o) cnt_q <= load_val;
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !reload_i) |=> $stable(cnt_q));
  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/kwdt_escalate.sv
`timescale 1ns/1ps
module kwdt_escalate
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 32
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t mode_i,
  input  logic  expire_i,
  input  logic  kick_i,
  input  logic  swrst_i,
  output logic  sys_rst_o,
  output logic  ext_rst_o,
  output logic  irq_o
);
  localparam int unsigned PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] pcnt_q;
  logic          irq_q, fire_rst, pin_act;

  // reset on expiry unless the interrupt stage absorbs it
  assign fire_rst = !mode_i.irq_en || (mode_i.dual && irq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      if (!mode_i.en || !mode_i.irq_en || kick_i) irq_q <= 1'b0;
      else if (expire_i)                          irq_q <= !fire_rst;

      if (swrst_i || (expire_i && fire_rst)) pcnt_q <= PW'(PULSE_TICKS);
      else if (pcnt_q != '0)                 pcnt_q <= pcnt_q - PW'(1);
    end
  end

  assign sys_rst_o = (pcnt_q != '0);
  assign pin_act   = sys_rst_o && mode_i.ext_en;
  assign ext_rst_o = mode_i.pol_hi ? pin_act : !pin_act;
  assign irq_o     = irq_q;

  assert_swrst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_i |=> sys_rst_o);
  assert_quiet_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i.en && !swrst_i && !sys_rst_o) |=> !sys_rst_o);
  assert_irq_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && mode_i.irq_en && !mode_i.dual && !swrst_i && !sys_rst_o) |=> (!sys_rst_o && irq_o));
  assert_second_stage_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && mode_i.irq_en && mode_i.dual && irq_o) |=> (sys_rst_o && !irq_o));
endmodule

// File: rtl/keyed_wdt.sv
`timescale 1ns/1ps
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned LEN_W       = 11,
  parameter int unsigned UNIT_TICKS  = 512,
  parameter int unsigned PULSE_TICKS = 32,
  parameter int unsigned LEN_RST     = 1984
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              sys_rst_o,
  output logic              ext_rst_o,
  output logic              irq_o
);
  mode_t            mode;
  logic [LEN_W-1:0] len_next;
  logic             reload, kick, swrst, expire;

  kwdt_regfile #(.LEN_W(LEN_W), .LEN_RST(LEN_RST)) i_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (bus_addr_i),
    .we_i       (bus_we_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .mode_o     (mode),
    .len_next_o (len_next),
    .reload_o   (reload),
    .kick_o     (kick),
    .swrst_o    (swrst)
  );

  kwdt_countdown #(.LEN_W(LEN_W), .UNIT_TICKS(UNIT_TICKS), .LEN_RST(LEN_RST)) i_countdown (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mode.en),
    .reload_i (reload),
    .len_i    (len_next),
    .expire_o (expire)
  );

  kwdt_escalate #(.PULSE_TICKS(PULSE_TICKS)) i_escalate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .expire_i  (expire),
    .kick_i    (kick),
    .swrst_i   (swrst),
    .sys_rst_o (sys_rst_o),
    .ext_rst_o (ext_rst_o),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;
  import keyed_wdt_pkg::*;

  localparam int L = 512;      // one length unit in cycles
  localparam int SEL_RD = 0, SEL_SYS = 1, SEL_EXT = 2, SEL_IRQ = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              sys_rst, ext_rst, irq;

  always #10 clk = ~clk;   // 50 MHz

  keyed_wdt i_keyed_wdt (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .sys_rst_o   (sys_rst),
    .ext_rst_o   (ext_rst),
    .irq_o       (irq)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard: parallel queues of expected items
  int          due_q[$];
  int          sel_q[$];
  logic [31:0] val_q[$];
  string       tag_q[$];

  task automatic expect_at(input int due, input int sel, input logic [31:0] val, input string tag);
    due_q.push_back(due);
    sel_q.push_back(sel);
    val_q.push_back(val);
    tag_q.push_back(tag);
  endtask

  function automatic logic [31:0] probe(input int sel);
    case (sel)
      SEL_RD:  return rdata;
      SEL_SYS: return {31'b0, sys_rst};
      SEL_EXT: return {31'b0, ext_rst};
      default: return {31'b0, irq};
    endcase
  endfunction

  // monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    for (int i = due_q.size() - 1; i >= 0; i--) begin
      if (due_q[i] == cyc) begin
        n_chk++;
        if (probe(sel_q[i]) !== val_q[i]) begin
          n_fail++;
          $display("FAIL %s: cycle %0d sel %0d actual %h expected %h",
                   tag_q[i], cyc, sel_q[i], probe(sel_q[i]), val_q[i]);
        end
        due_q.delete(i); sel_q.delete(i); val_q.delete(i); tag_q.delete(i);
      end else if (due_q[i] < cyc) begin
        n_chk++;
        n_fail++;
        $display("FAIL %s: item due %0d missed, actual none expected %h",
                 tag_q[i], due_q[i], val_q[i]);
        due_q.delete(i); sel_q.delete(i); val_q.delete(i); tag_q.delete(i);
      end
    end
  end

  // driver tasks; on return cyc holds the write edge
  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; we = 1'b0;
    expect_at(cyc + 1, SEL_RD, exp, tag);
    @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1: watchdog expired, actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int w, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(OFS_MODE, 32'h0, "R1");
    bus_rd(OFS_LEN, 32'h0000_F800, "R1");
    expect_at(cyc + 1, SEL_SYS, 0, "R1");
    expect_at(cyc + 1, SEL_EXT, 1, "R1");
    expect_at(cyc + 1, SEL_IRQ, 0, "R1");

    // R2 mode key
    bus_wr(OFS_MODE, 32'h2100_0041);
    bus_rd(OFS_MODE, 32'h0, "R2");
    bus_wr(OFS_MODE, 32'h2200_00FE);
    bus_rd(OFS_MODE, 32'h0000_005E, "R2");
    bus_wr(OFS_MODE, 32'h2200_0000);
    bus_rd(OFS_MODE, 32'h0, "R2");

    // R3 length key and field
    bus_wr(OFS_LEN, 32'h0000_0027);
    bus_rd(OFS_LEN, 32'h0000_F800, "R3");
    bus_wr(OFS_LEN, 32'hFFFF_0048);
    bus_rd(OFS_LEN, 32'h0000_0040, "R3");
    bus_wr(OFS_LEN, 32'h0000_0028);
    bus_rd(OFS_LEN, 32'h0000_0020, "R3");

    // R5 strobe registers read zero
    bus_rd(OFS_KICK, 32'h0, "R5");
    bus_rd(OFS_SWRST, 32'h0, "R5");

    // R4 / R5: expiry timed from the last valid restart
    bus_wr(OFS_MODE, 32'h2200_0001);
    bus_wr(OFS_KICK, KICK_CODE);
    w = cyc;
    repeat (100) @(negedge clk);
    bus_wr(OFS_KICK, 32'h0000_1970);
    bus_wr(OFS_KICK, 32'h0001_1971);
    expect_at(w + L - 1,  SEL_SYS, 0, "R5");
    expect_at(w + L,      SEL_SYS, 1, "R4");
    expect_at(w + L + 31, SEL_SYS, 1, "R4");
    expect_at(w + L + 32, SEL_SYS, 0, "R4");
    expect_at(w + L,      SEL_EXT, 1, "R8");
    expect_at(w + L,      SEL_IRQ, 0, "R4");
    wait_until(w + L + 40);
    bus_wr(OFS_MODE, 32'h2200_0000);

    // R7 disabled: no reset
    w = cyc;
    for (int j = 1; j <= 8; j++) expect_at(w + j * 128, SEL_SYS, 0, "R7");
    wait_until(w + 8 * 128 + 2);

    // R6 software reset
    bus_wr(OFS_SWRST, 32'h0000_1208);
    expect_at(cyc + 1, SEL_SYS, 0, "R6");
    expect_at(cyc + 2, SEL_SYS, 0, "R6");
    repeat (3) @(negedge clk);
    bus_wr(OFS_SWRST, SWRST_CODE);
    w = cyc;
    expect_at(w + 1,  SEL_SYS, 1, "R6");
    expect_at(w + 31, SEL_SYS, 1, "R6");
    expect_at(w + 32, SEL_SYS, 0, "R6");
    wait_until(w + 40);

    // R8 pin polarity; R3 length write reloads
    bus_wr(OFS_MODE, 32'h2200_0007);
    bus_wr(OFS_LEN, 32'h0000_0028);
    w = cyc;
    expect_at(w + L - 1,  SEL_EXT, 0, "R8");
    expect_at(w + L,      SEL_EXT, 1, "R8");
    expect_at(w + L,      SEL_SYS, 1, "R3");
    expect_at(w + L + 32, SEL_EXT, 0, "R8");
    wait_until(w + L + 40);
    bus_wr(OFS_MODE, 32'h2200_0005);
    expect_at(w + 2 * L - 1,  SEL_EXT, 1, "R8");
    expect_at(w + 2 * L,      SEL_EXT, 0, "R8");
    expect_at(w + 2 * L + 32, SEL_EXT, 1, "R8");
    wait_until(w + 2 * L + 40);
    bus_wr(OFS_MODE, 32'h2200_0000);

    // R9 interrupt only
    bus_wr(OFS_MODE, 32'h2200_0009);
    bus_wr(OFS_KICK, KICK_CODE);
    w = cyc;
    expect_at(w + L - 1,  SEL_IRQ, 0, "R9");
    expect_at(w + L,      SEL_IRQ, 1, "R9");
    expect_at(w + L,      SEL_SYS, 0, "R9");
    expect_at(w + L + 1,  SEL_SYS, 0, "R9");
    expect_at(w + L + 10, SEL_IRQ, 1, "R9");
    wait_until(w + L + 20);
    bus_wr(OFS_KICK, KICK_CODE);
    expect_at(cyc + 1, SEL_IRQ, 0, "R9");
    repeat (3) @(negedge clk);
    bus_wr(OFS_MODE, 32'h2200_0000);

    // R10 dual stage escalation
    bus_wr(OFS_MODE, 32'h2200_0049);
    bus_wr(OFS_KICK, KICK_CODE);
    w = cyc;
    expect_at(w + L,         SEL_IRQ, 1, "R10");
    expect_at(w + L,         SEL_SYS, 0, "R10");
    expect_at(w + 2 * L - 1, SEL_IRQ, 1, "R10");
    expect_at(w + 2 * L - 1, SEL_SYS, 0, "R10");
    expect_at(w + 2 * L,     SEL_SYS, 1, "R10");
    expect_at(w + 2 * L,     SEL_IRQ, 0, "R10");
    wait_until(w + 2 * L + 40);
    bus_wr(OFS_KICK, KICK_CODE);
    w = cyc;
    expect_at(w + L, SEL_IRQ, 1, "R10");
    wait_until(w + L + 10);
    bus_wr(OFS_KICK, KICK_CODE);
    k = cyc;
    expect_at(k + 1,     SEL_IRQ, 0, "R10");
    expect_at(k + L,     SEL_IRQ, 1, "R10");
    expect_at(k + L,     SEL_SYS, 0, "R10");
    expect_at(k + L + 1, SEL_SYS, 0, "R10");
    wait_until(k + L + 5);
    bus_wr(OFS_MODE, 32'h2200_0000);

    while (due_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule